// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small processor from the moment a fault or interrupt is raised to the moment the first instruction of its handler is fetched. When it accepts a request it latches the current status register and the program counter to be saved. It then writes back a status value with supervisor mode set and tracing off; an interrupt also clears the master bit and raises the priority mask to the level being serviced. It steps the supervisor stack pointer down to make room for an 8-byte frame.

A fault takes its vector number straight from the requester. An interrupt gets its vector from an acknowledge read, whose address carries the interrupt level. The sequencer writes the saved PC and a word holding the format, the vector and the saved status onto the supervisor stack. It reads the handler address from a vector table whose base is forced onto a 1 MB boundary, then issues the fetch of the handler's first opcode. Each access waits for the bus to acknowledge it. Requests that arrive while a sequence is running are not accepted.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: busy_o, bus_req_o, sr_we_o, ssp_we_o and done_o are all low.
- R2: A request seen on req_i while idle is accepted at that clock edge. In the next cycle sr_we_o is high for one cycle. sr_o then equals the status captured at acceptance with bit 13 (supervisor) set and bit 15 (trace) cleared, and no bus access is made in that cycle.
- R3: For an interrupt (req_irq_i high at acceptance), sr_o also has bit 12 (master) cleared and bits 10:8 (priority mask) equal to req_lvl_i. All other bits keep their captured values.
- R4: In the same cycle as sr_we_o, ssp_we_o is high and ssp_o equals ssp_i with its low two bits cleared, minus 8.
- R5: An interrupt starts with a read of cycle type 01 at address IACK_BASE + 4 × level, and bits 7:0 of its data become the vector number. A fault makes no such read and uses req_vec_i as the vector number.
- R6: The PC write uses cycle type 00 at frame base + 4, where the frame base is the new ssp_o value. Its data is next_pc_i if req_next_i was high at acceptance, and fault_pc_i otherwise.
- R7: The status write uses cycle type 00 at the frame base. Its data has bits 31:30 = 01, bits 29:28 = the low two bits of the original ssp_i, bits 27:24 = 0, bits 23:16 = the vector number and bits 15:0 = the captured status.
- R8: The vector read uses cycle type 10 at vbr_i with bits 19:0 cleared, plus 4 × the vector number. Its data is the handler address.
- R9: The handler fetch is a read of cycle type 11 at the handler address. done_o is high only in the cycle the fetch is acknowledged, pc_o then shows the handler address, and busy_o is low in the next cycle.
- R10: Accesses come in the fixed order acknowledge (interrupts only), PC write, status write, vector read, handler fetch. While bus_req_o is high and bus_ack_i is low, the address, data, cycle type and direction do not change.
- R11: req_i is ignored while busy_o is high. It alters neither the running sequence nor starts another one after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request |
| req_irq_i | input | 1 | Request is an interrupt |
| req_vec_i | input | 8 | Vector number for a fault |
| req_lvl_i | input | 3 | Interrupt level |
| req_next_i | input | 1 | Save next PC instead of faulting PC |
| fault_pc_i | input | 32 | Address of faulting instruction |
| next_pc_i | input | 32 | Address of next instruction |
| sr_i | input | 16 | Current status register |
| sr_o | output | 16 | New status register value |
| sr_we_o | output | 1 | Status register write enable |
| ssp_i | input | 32 | Current supervisor stack pointer |
| ssp_o | output | 32 | New supervisor stack pointer |
| ssp_we_o | output | 1 | Stack pointer write enable |
| vbr_i | input | 32 | Vector table base |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_cyc_o | output | 2 | Cycle type: 00 data, 01 acknowledge, 10 vector, 11 fetch |
| bus_addr_o | output | 32 | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Handler fetch acknowledged |
| pc_o | output | 32 | Handler start address |

## Verification
The bus outputs are decoded straight from the state register, so a state that is wrong, skipped or stuck shows on the cycle type and address of the very next request. A sequence that hangs leaves bus_req_o high or busy_o stuck, and this shows within a few cycles. Wrong latched data (status, vector, PC, misalignment) appears in the frame write data or in the vector-table address one or two accesses later. The bench therefore compares every access in full, in order, and also compares the wait cycles in between.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SR_UPD, ST_VEC, ST_PUSH_PC, ST_PUSH_SR, ST_VEC_FETCH, ST_HND_FETCH
  } exc_state_e;

  typedef enum logic [1:0] {
    CYC_DATA = 2'b00, CYC_IACK = 2'b01, CYC_VECTOR = 2'b10, CYC_IFETCH = 2'b11
  } bus_cyc_e;

  localparam int SR_T_BIT    = 15;
  localparam int SR_S_BIT    = 13;
  localparam int SR_M_BIT    = 12;
  localparam int SR_IPL_LSB  = 8;
  localparam int FRAME_BYTES = 8;
endpackage

// File: rtl/exc_sr_calc.sv
module exc_sr_calc import exc_entry_pkg::*; #(
  parameter int SR_W  = 16,
  parameter int LVL_W = 3
) (
  input  logic [SR_W-1:0]  sr_i,
  input  logic             irq_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [SR_W-1:0]  sr_o
);
  always_comb begin
    sr_o = sr_i;
    sr_o[SR_S_BIT] = 1'b1;
    sr_o[SR_T_BIT] = 1'b0;
    if (irq_i) begin
      sr_o[SR_M_BIT] = 1'b0;
      sr_o[SR_IPL_LSB +: LVL_W] = lvl_i;
    end
  end
endmodule

// File: rtl/exc_bus_gen.sv
module exc_bus_gen import exc_entry_pkg::*; #(
  parameter int             AW        = 32,
  parameter int             SR_W      = 16,
  parameter int             VEC_W     = 8,
  parameter int             LVL_W     = 3,
  parameter int             VBR_ALIGN = 20,
  parameter logic [AW-1:0]  IACK_BASE = 32'hFFFF_FFE0
) (
  input  exc_state_e       state_i,
  input  logic             irq_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [AW-1:0]    frame_sp_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [SR_W-1:0]  saved_sr_i,
  input  logic [1:0]       mis_i,
  input  logic [AW-1:0]    vbr_i,
  input  logic [AW-1:0]    handler_i,
  output logic             req_o,
  output logic             we_o,
  output logic [1:0]       cyc_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    wdata_o
);
  localparam int FMT_W = AW - VEC_W - SR_W;

  logic [AW-1:0]    vbr_base;
  logic [FMT_W-1:0] fmt;
  logic             unused_vbr;

  assign vbr_base   = {vbr_i[AW-1:VBR_ALIGN], {VBR_ALIGN{1'b0}}};
  assign unused_vbr = ^vbr_i[VBR_ALIGN-1:0];
  assign fmt        = {2'b01, mis_i, {(FMT_W-4){1'b0}}};

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    cyc_o   = CYC_DATA;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_VEC: if (irq_i) begin
        req_o  = 1'b1;
        cyc_o  = CYC_IACK;
        addr_o = IACK_BASE | (AW'(lvl_i) << 2);
      end
      ST_PUSH_PC: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = frame_sp_i + AW'(4);
        wdata_o = pc_i;
      end
      ST_PUSH_SR: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = frame_sp_i;
        wdata_o = {fmt, vec_i, saved_sr_i};
      end
      ST_VEC_FETCH: begin
        req_o  = 1'b1;
        cyc_o  = CYC_VECTOR;
        addr_o = vbr_base + (AW'(vec_i) << 2);
      end
      ST_HND_FETCH: begin
        req_o  = 1'b1;
        cyc_o  = CYC_IFETCH;
        addr_o = handler_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq import exc_entry_pkg::*; #(
  parameter int             AW        = 32,
  parameter int             SR_W      = 16,
  parameter int             VEC_W     = 8,
  parameter int             LVL_W     = 3,
  parameter int             VBR_ALIGN = 20,
  parameter logic [AW-1:0]  IACK_BASE = 32'hFFFF_FFE0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_irq_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic [LVL_W-1:0] req_lvl_i,
  input  logic             req_next_i,
  input  logic [AW-1:0]    fault_pc_i,
  input  logic [AW-1:0]    next_pc_i,
  input  logic [SR_W-1:0]  sr_i,
  output logic [SR_W-1:0]  sr_o,
  output logic             sr_we_o,
  input  logic [AW-1:0]    ssp_i,
  output logic [AW-1:0]    ssp_o,
  output logic             ssp_we_o,
  input  logic [AW-1:0]    vbr_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [1:0]       bus_cyc_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [AW-1:0]    bus_wdata_o,
  input  logic [AW-1:0]    bus_rdata_i,
  input  logic             bus_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    pc_o
);
  exc_state_e       state_q, state_d;
  logic [SR_W-1:0]  saved_sr_q;
  logic             irq_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    pc_q, frame_sp_q, handler_q;
  logic [1:0]       mis_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i) state_d = ST_SR_UPD;
      ST_SR_UPD:    state_d = ST_VEC;
      ST_VEC:       if (!irq_q || bus_ack_i) state_d = ST_PUSH_PC;
      ST_PUSH_PC:   if (bus_ack_i) state_d = ST_PUSH_SR;
      ST_PUSH_SR:   if (bus_ack_i) state_d = ST_VEC_FETCH;
      ST_VEC_FETCH: if (bus_ack_i) state_d = ST_HND_FETCH;
      ST_HND_FETCH: if (bus_ack_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      saved_sr_q <= '0;
      irq_q      <= 1'b0;
      lvl_q      <= '0;
      vec_q      <= '0;
      pc_q       <= '0;
      frame_sp_q <= '0;
      mis_q      <= '0;
      handler_q  <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          saved_sr_q <= sr_i;
          irq_q      <= req_irq_i;
          lvl_q      <= req_lvl_i;
          vec_q      <= req_vec_i;
          pc_q       <= req_next_i ? next_pc_i : fault_pc_i;
        end
        ST_SR_UPD: begin
          frame_sp_q <= ssp_o;
          mis_q      <= ssp_i[1:0];
        end
        ST_VEC:       if (irq_q && bus_ack_i) vec_q <= bus_rdata_i[VEC_W-1:0];
        ST_VEC_FETCH: if (bus_ack_i) handler_q <= bus_rdata_i;
        default: ;
      endcase
    end
  end

  exc_sr_calc #(.SR_W(SR_W), .LVL_W(LVL_W)) u_sr_calc (
    .sr_i  (saved_sr_q),
    .irq_i (irq_q),
    .lvl_i (lvl_q),
    .sr_o  (sr_o)
  );

  exc_bus_gen #(
    .AW(AW), .SR_W(SR_W), .VEC_W(VEC_W), .LVL_W(LVL_W),
    .VBR_ALIGN(VBR_ALIGN), .IACK_BASE(IACK_BASE)
  ) u_bus_gen (
    .state_i    (state_q),
    .irq_i      (irq_q),
    .lvl_i      (lvl_q),
    .vec_i      (vec_q),
    .frame_sp_i (frame_sp_q),
    .pc_i       (pc_q),
    .saved_sr_i (saved_sr_q),
    .mis_i      (mis_q),
    .vbr_i      (vbr_i),
    .handler_i  (handler_q),
    .req_o      (bus_req_o),
    .we_o       (bus_we_o),
    .cyc_o      (bus_cyc_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o)
  );

  // align down first, then reserve the frame
  assign ssp_o    = {ssp_i[AW-1:2], 2'b00} - AW'(FRAME_BYTES);
  assign ssp_we_o = (state_q == ST_SR_UPD);
  assign sr_we_o  = (state_q == ST_SR_UPD);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_HND_FETCH) && bus_ack_i;
  assign pc_o     = handler_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW   = 32,
  parameter int SR_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [SR_W-1:0] sr_o,
  input logic            sr_we_o,
  input logic [AW-1:0]   ssp_o,
  input logic            ssp_we_o,
  input logic            bus_req_o,
  input logic            bus_we_o,
  input logic [1:0]      bus_cyc_o,
  input logic [AW-1:0]   bus_addr_o,
  input logic [AW-1:0]   bus_wdata_o,
  input logic            bus_ack_i,
  input logic            busy_o,
  input logic            done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o && !sr_we_o && !ssp_we_o && !done_o);

  p_accept_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i |=> sr_we_o && ssp_we_o);

  p_mode_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> sr_o[13] && !sr_o[15] && !bus_req_o);

  p_ssp_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssp_we_o |-> sr_we_o && ssp_o[1:0] == 2'b00);

  p_push_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> bus_addr_o[1:0] == 2'b00 && bus_cyc_o == 2'b00);

  p_bus_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_cyc_o)
      && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_done_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bus_req_o && bus_ack_i && bus_cyc_o == 2'b11 && !bus_we_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_no_reaccept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |=> !sr_we_o);
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW), .SR_W(SR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .sr_o        (sr_o),
  .sr_we_o     (sr_we_o),
  .ssp_o       (ssp_o),
  .ssp_we_o    (ssp_we_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_cyc_o   (bus_cyc_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam logic [31:0] IACK_BASE = 32'hFFFF_FFE0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_irq_i = 1'b0, req_next_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic [2:0]  req_lvl_i = '0;
  logic [31:0] fault_pc_i = '0, next_pc_i = '0, ssp_i = '0, vbr_i = '0, bus_rdata_i = '0;
  logic [15:0] sr_i = '0;
  logic        bus_ack_i = 1'b0;
  logic [15:0] sr_o;
  logic        sr_we_o, ssp_we_o, bus_req_o, bus_we_o, busy_o, done_o;
  logic [1:0]  bus_cyc_o;
  logic [31:0] ssp_o, bus_addr_o, bus_wdata_o, pc_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_seq dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic entry(input bit irq, input logic [2:0] lvl, input logic [7:0] fvec,
                       input bit nxt, input logic [31:0] ssp, input logic [15:0] sr,
                       input logic [31:0] vbr, input int lat, input bit poke);
    logic [31:0] e_addr[5];
    logic [1:0]  e_cyc[5];
    logic        e_we[5];
    logic [31:0] e_wd[5];
    logic [31:0] base, hnd, pv, pa;
    logic [15:0] esr;
    logic [7:0]  v, iv;
    int n, idx, wt, guard, pk;
    iv   = 8'h40 + 8'(lvl) * 8'd3;
    v    = irq ? iv : fvec;
    hnd  = 32'h0001_0000 + 32'(v) * 32'd16;
    base = {ssp[31:2], 2'b00} - 32'd8;
    esr  = sr; esr[13] = 1'b1; esr[15] = 1'b0;
    if (irq) begin esr[12] = 1'b0; esr[10:8] = lvl; end
    pv = nxt ? 32'h0000_5A04 + 32'(fvec) : 32'h0000_3000 + 32'(fvec);
    n = 0;
    if (irq) begin e_addr[n] = IACK_BASE | (32'(lvl) << 2); e_cyc[n] = 2'b01; e_we[n] = 0; e_wd[n] = 0; n++; end
    e_addr[n] = base + 32'd4; e_cyc[n] = 2'b00; e_we[n] = 1; e_wd[n] = pv; n++;
    e_addr[n] = base; e_cyc[n] = 2'b00; e_we[n] = 1;
    e_wd[n] = {2'b01, ssp[1:0], 4'b0000, v, sr}; n++;
    e_addr[n] = {vbr[31:20], 20'h0} + 32'(v) * 32'd4; e_cyc[n] = 2'b10; e_we[n] = 0; e_wd[n] = 0; n++;
    e_addr[n] = hnd; e_cyc[n] = 2'b11; e_we[n] = 0; e_wd[n] = 0; n++;

    @(negedge clk_i);
    req_i = 1; req_irq_i = irq; req_lvl_i = lvl; req_vec_i = fvec; req_next_i = nxt;
    fault_pc_i = 32'h0000_3000 + 32'(fvec); next_pc_i = 32'h0000_5A04 + 32'(fvec);
    ssp_i = ssp; sr_i = sr; vbr_i = vbr;
    @(negedge clk_i);
    req_i = 0; sr_i = ~sr; fault_pc_i = '1; next_pc_i = '1; // latched values must be used
    #1;
    chk(sr_we_o === 1'b1, "R2 sr_we", 32'(sr_we_o), 1);
    chk(sr_o === esr, irq ? "R3 irq sr" : "R2 sr", 32'(sr_o), 32'(esr));
    chk(bus_req_o === 1'b0, "R2 no bus", 32'(bus_req_o), 0);
    chk(ssp_we_o === 1'b1 && ssp_o === base, "R4 ssp", ssp_o, base);

    idx = 0; wt = 0; guard = 0; pk = 0; pa = '0;
    while (idx < n && guard < 100) begin
      @(negedge clk_i);
      bus_ack_i = 0;
      if (poke && pk == 1) begin req_i = 0; pk = 2; end
      if (poke && pk == 0 && idx == 1) begin req_i = 1; pk = 1; end
      #1;
      guard++;
      if (bus_req_o) begin
        if (wt == 0) pa = bus_addr_o;
        else chk(bus_addr_o === pa, "R10 hold", bus_addr_o, pa);
        if (wt == lat) begin
          chk(bus_addr_o === e_addr[idx], "R10 order/addr R5 R6 R7 R8", bus_addr_o, e_addr[idx]);
          chk(bus_cyc_o === e_cyc[idx] && bus_we_o === e_we[idx], "R10 cyc/dir",
              {29'b0, bus_we_o, bus_cyc_o}, {29'b0, e_we[idx], e_cyc[idx]});
          if (e_we[idx]) chk(bus_wdata_o === e_wd[idx], idx == n - 2 ? "R7 frame" : "R6 pc", bus_wdata_o, e_wd[idx]);
          bus_rdata_i = (e_cyc[idx] == 2'b01) ? {24'hABCDEF, iv} : hnd;
          bus_ack_i = 1;
          #1;
          if (idx == n - 1) begin
            chk(done_o === 1'b1, "R9 done", 32'(done_o), 1);
            chk(pc_o === hnd, "R9 pc_o", pc_o, hnd);
          end else chk(done_o === 1'b0, "R9 early done", 32'(done_o), 0);
          idx++; wt = 0;
        end else wt++;
      end
    end
    if (idx < n) chk(0, "R10 stall", 32'(idx), 32'(n));
    @(negedge clk_i);
    bus_ack_i = 0; req_i = 0;
    #1;
    chk(busy_o === 1'b0, "R9 busy drop", 32'(busy_o), 0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk_i); #1;
        chk(busy_o === 1'b0 && sr_we_o === 1'b0 && bus_req_o === 1'b0, "R11 ignored",
            {30'b0, busy_o, bus_req_o}, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(busy_o === 0 && bus_req_o === 0 && sr_we_o === 0 && ssp_we_o === 0 && done_o === 0,
        "R1 reset", {27'b0, busy_o, bus_req_o, sr_we_o, ssp_we_o, done_o}, 0);
    rst_ni = 1;
    // faults: vectors, PC choice, all SSP misalignments, latencies
    for (int i = 0; i < 16; i++)
      entry(0, 3'd0, 8'(i * 23 + 2), i[0], 32'h2000_1000 + 32'(i * 37),
            16'h8705 ^ 16'(i * 16'h1111), 32'h0030_0000 | 32'(i * 32'h1_2345), i % 3, 0);
    entry(0, 3'd0, 8'hFF, 1, 32'h0000_0003, 16'hFFFF, 32'hFFF8_0ABC, 1, 0);
    // interrupts: every level, several latencies
    for (int l = 1; l < 8; l++)
      for (int k = 0; k < 3; k++)
        entry(1, 3'(l), 8'h11, k[0], 32'h1000_0000 + 32'(l * 4 + k), 16'hB0FF ^ 16'(l << 8),
              32'h0120_0000 + 32'(k), k, 0);
    // requests while busy
    entry(0, 3'd0, 8'h0C, 0, 32'h0000_8002, 16'h2700, 32'h0010_0000, 2, 1);
    entry(1, 3'd5, 8'h00, 1, 32'h0000_4001, 16'h0000, 32'h0000_0000, 1, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule